// File: doc/BRIEF.md
# Serial DAC Write-Frame Receiver

This block is the digital front end of a single-channel 16-bit voltage-output converter. An external controller writes to it over a three-wire, write-only serial port: an active-low frame select, a serial clock and a data line. Each write is a fixed 24-bit word, sent most significant bit first. A bit is taken on every falling serial clock edge while select is low. On the 24th such edge the word takes effect. It carries a 16-bit converter code and a 2-bit output-state field, and both are applied together.

If select rises before the 24th edge, the partial word is thrown away and nothing changes. Any edges after the 24th are ignored until select has gone high and then low again. The accepted word is held in the serial clock domain. A toggle request, passed through a two-flop synchronizer, tells the system clock domain to copy it into the output registers. The outputs drive the converter core with a code, the raw mode value and a one-hot termination select.

Top module: `dacfrm_rx`

## Requirements
- R1: The outputs do not change until exactly 24 falling serial clock edges have been taken within one low period of select. Bits are taken most significant first.
- R2: Word layout, with bit 23 sent first: bits 23..18 are padding, and their values have no effect. Bits 17..16 are the mode field. Bits 15..0 are the code, bit 15 first.
- R3: The new code and the new mode appear on `dac_code` and `pd_mode` together, within four system clock cycles after the 24th falling edge. Between updates both outputs hold steady.
- R4: If select rises after fewer than 24 edges, the outputs keep their previous values. The next frame counts its bits from zero.
- R5: Falling edges after the 24th, while select stays low, change nothing. The bit count never exceeds 24.
- R6: `term_sel` is one-hot, and the set bit's index equals the mode value: 0 drives the output normally, 1 ties it to ground through 1 kΩ, 2 ties it to ground through 100 kΩ, and 3 leaves it high impedance.
- R7: After reset the mode is 0. The code is 0x0000 when `RESET_MID` is 0 and 0x8000 when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the output registers |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| sel_n | input | 1 | Active-low frame select; high clears a frame in progress |
| sclk | input | 1 | Serial clock; data taken on its falling edge |
| sdin | input | 1 | Serial data in |
| dac_code | output | 16 | Code for the converter core |
| pd_mode | output | 2 | Applied output-state mode value |
| term_sel | output | 4 | One-hot output termination select, indexed by mode |

## Verification
The bench aborts frames after a single bit and after 23 bits. A receiver that applies partial words, or that keeps a stale count, would change the outputs or misalign the next frame. It clocks extra edges after the 24th with select held low. A receiver that does not lock would shift on and load garbage. It also sends words with nonzero padding to catch decoding that is off by a position. It probes the outputs one edge before and a few clocks after the 24th edge. This catches both early updates and updates that lose the mode or the code.

// File: rtl/dacfrm_pkg.sv
package dacfrm_pkg;
  localparam int PAD_W  = 6;
  localparam int MODE_W = 2;
  localparam int CODE_W = 16;
  localparam int TERM_N = 1 << MODE_W;

  // Power-on code: zero-scale or midscale.
  function automatic logic [CODE_W-1:0] pwr_on_code(input logic mid);
    pwr_on_code = mid ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
  endfunction
endpackage

// File: rtl/dacfrm_shift.sv
module dacfrm_shift #(
  parameter int PAD_W     = 6,
  parameter int MODE_W    = 2,
  parameter int CODE_W    = 16,
  parameter bit RESET_MID = 1'b0
) (
  input  logic                               rst_n,
  input  logic                               sel_n,
  input  logic                               sclk,
  input  logic                               sdin,
  output logic [CODE_W-1:0]                  hold_code,
  output logic [MODE_W-1:0]                  hold_mode,
  output logic                               req_tgl,
  output logic [$clog2(PAD_W+MODE_W+CODE_W+1)-1:0] bit_cnt,
  output logic                               frame_end
);
  localparam int FRAME_W = PAD_W + MODE_W + CODE_W;
  localparam int PAY_W   = MODE_W + CODE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic             frm_rst;
  logic             locked;
  logic [PAY_W-2:0] shreg;  // padding bits fall off the top

  assign frm_rst   = !rst_n || sel_n;
  assign locked    = (bit_cnt == CNT_W'(FRAME_W));
  assign frame_end = !sel_n && (bit_cnt == CNT_W'(FRAME_W - 1));

  always_ff @(negedge sclk or posedge frm_rst) begin
    if (frm_rst) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (!locked) begin
      bit_cnt <= bit_cnt + 1'b1;
      shreg   <= {shreg[PAY_W-3:0], sdin};
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_code <= dacfrm_pkg::pwr_on_code(RESET_MID);
      hold_mode <= '0;
      req_tgl   <= 1'b0;
    end else if (frame_end) begin
      {hold_mode, hold_code} <= {shreg, sdin};
      req_tgl                <= ~req_tgl;
    end
  end
endmodule

// File: rtl/dacfrm_apply.sv
module dacfrm_apply #(
  parameter int MODE_W    = 2,
  parameter int CODE_W    = 16,
  parameter bit RESET_MID = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_tgl,
  input  logic [CODE_W-1:0] hold_code,
  input  logic [MODE_W-1:0] hold_mode,
  output logic [CODE_W-1:0] dac_code,
  output logic [MODE_W-1:0] pd_mode,
  output logic              upd_stb
);
  logic sync1, sync2, sync3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      sync3 <= 1'b0;
    end else begin
      sync1 <= req_tgl;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign upd_stb = sync2 ^ sync3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code <= dacfrm_pkg::pwr_on_code(RESET_MID);
      pd_mode  <= '0;
    end else if (upd_stb) begin
      dac_code <= hold_code;
      pd_mode  <= hold_mode;
    end
  end
endmodule

// File: rtl/dacfrm_term.sv
module dacfrm_term #(
  parameter int MODE_W = 2
) (
  input  logic [MODE_W-1:0]      mode,
  output logic [(1<<MODE_W)-1:0] term_sel
);
  localparam int TERM_N = 1 << MODE_W;

  for (genvar i = 0; i < TERM_N; i++) begin : g_term
    assign term_sel[i] = (mode == MODE_W'(i));
  end
endmodule

// File: rtl/dacfrm_rx.sv
module dacfrm_rx #(
  parameter bit RESET_MID = 1'b0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_n,
  input  logic                          sclk,
  input  logic                          sdin,
  output logic [dacfrm_pkg::CODE_W-1:0] dac_code,
  output logic [dacfrm_pkg::MODE_W-1:0] pd_mode,
  output logic [dacfrm_pkg::TERM_N-1:0] term_sel
);
  localparam int PAD_W   = dacfrm_pkg::PAD_W;
  localparam int MODE_W  = dacfrm_pkg::MODE_W;
  localparam int CODE_W  = dacfrm_pkg::CODE_W;
  localparam int FRAME_W = PAD_W + MODE_W + CODE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [CODE_W-1:0] hold_code;
  logic [MODE_W-1:0] hold_mode;
  logic              req_tgl;
  logic [CNT_W-1:0]  bit_cnt;
  logic              frame_end;
  logic              upd_stb;

  dacfrm_shift #(
    .PAD_W(PAD_W), .MODE_W(MODE_W), .CODE_W(CODE_W), .RESET_MID(RESET_MID)
  ) u_shift (
    .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
    .hold_code(hold_code), .hold_mode(hold_mode), .req_tgl(req_tgl),
    .bit_cnt(bit_cnt), .frame_end(frame_end)
  );

  dacfrm_apply #(
    .MODE_W(MODE_W), .CODE_W(CODE_W), .RESET_MID(RESET_MID)
  ) u_apply (
    .clk(clk), .rst_n(rst_n), .req_tgl(req_tgl),
    .hold_code(hold_code), .hold_mode(hold_mode),
    .dac_code(dac_code), .pd_mode(pd_mode), .upd_stb(upd_stb)
  );

  dacfrm_term #(.MODE_W(MODE_W)) u_term (
    .mode(pd_mode), .term_sel(term_sel)
  );
endmodule

// File: rtl/dacfrm_rx_chk.sv
module dacfrm_rx_chk #(
  parameter int CODE_W    = 16,
  parameter int MODE_W    = 2,
  parameter int CNT_W     = 5,
  parameter int FRAME_W   = 24,
  parameter bit RESET_MID = 1'b0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sel_n,
  input logic [CNT_W-1:0]          bit_cnt,
  input logic                      upd_stb,
  input logic [CODE_W-1:0]         hold_code,
  input logic [MODE_W-1:0]         hold_mode,
  input logic [CODE_W-1:0]         dac_code,
  input logic [MODE_W-1:0]         pd_mode,
  input logic [(1<<MODE_W)-1:0]    term_sel
);
  AST_RESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dac_code == dacfrm_pkg::pwr_on_code(RESET_MID)) && (pd_mode == '0)); // R7
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |=> $stable(dac_code) && $stable(pd_mode)); // R3
  AST_APPLY_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> (dac_code == $past(hold_code)) && (pd_mode == $past(hold_mode))); // R3
  AST_ABORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (bit_cnt == '0)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W)); // R5
  AST_TERM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(term_sel) == 1); // R6
endmodule

bind dacfrm_rx dacfrm_rx_chk #(
  .CODE_W(CODE_W), .MODE_W(MODE_W), .CNT_W(CNT_W), .FRAME_W(FRAME_W), .RESET_MID(RESET_MID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .bit_cnt(bit_cnt), .upd_stb(upd_stb),
  .hold_code(hold_code), .hold_mode(hold_mode), .dac_code(dac_code),
  .pd_mode(pd_mode), .term_sel(term_sel)
);

// File: tb/dacfrm_rx_test.sv
module dacfrm_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1;
  logic        sclk = 1'b1;
  logic        sdin = 1'b0;
  logic [15:0] code_m, code_z;
  logic [1:0]  mode_m, mode_z;
  logic [3:0]  term_m, term_z;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  dacfrm_rx #(.RESET_MID(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
    .dac_code(code_m), .pd_mode(mode_m), .term_sel(term_m)
  );
  dacfrm_rx uut_z (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
    .dac_code(code_z), .pd_mode(mode_z), .term_sel(term_z)
  );

  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    24'h00_1234, 24'h01_ABCD, 24'h02_0001, 24'h03_FFFF,
    24'hFC_5A5A, 24'hFE_8000, 24'h55_0F0F, 24'h00_0000
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] want_term(input logic [1:0] m);
    case (m)
      2'd0: want_term = 4'b0001;
      2'd1: want_term = 4'b0010;
      2'd2: want_term = 4'b0100;
      default: want_term = 4'b1000;
    endcase
  endfunction

  task automatic shift_bits(input logic [23:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sdin = w[23-i];
      #20 sclk = 1'b0;
      #20 sclk = 1'b1;
    end
  endtask

  task automatic send_frame(input logic [23:0] w);
    sel_n = 1'b0;
    #20;
    shift_bits(w, 24);
    #20 sel_n = 1'b1;
    #80;
  endtask

  task automatic chk_out(input string tag, input logic [15:0] c, input logic [1:0] m);
    chk({tag, " code"}, 32'(code_m), 32'(c));
    chk({tag, " mode"}, 32'(mode_m), 32'(m));
    chk({tag, " term"}, 32'(term_m), 32'(want_term(m)));
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #40 rst_n = 1'b1;
    #40;
    // R7: reset values for both instances
    chk("R7 mid code", 32'(code_m), 32'h8000);
    chk("R7 zero code", 32'(code_z), 32'h0000);
    chk("R7 mode", 32'(mode_m), 32'h0);
    chk("R6 reset term", 32'(term_m), 32'h1);

    // R1 R2 R6: table of frames
    for (int v = 0; v < NV; v++) begin
      send_frame(VEC[v]);
      chk_out($sformatf("R2 vec%0d", v), VEC[v][15:0], VEC[v][17:16]);
    end
    chk("R2 zero-reset unit", 32'(code_z), 32'h0000);

    // R4: abort after 23 bits, then after 1 bit
    send_frame(24'h01_1111);
    sel_n = 1'b0; #20;
    shift_bits(24'h02_2222, 23);
    #20 sel_n = 1'b1; #80;
    chk_out("R4 abort23", 16'h1111, 2'd1);
    sel_n = 1'b0; #20;
    shift_bits(24'hFF_FFFF, 1);
    #20 sel_n = 1'b1; #80;
    chk_out("R4 abort1", 16'h1111, 2'd1);
    send_frame(24'h03_C3C3);
    chk_out("R4 restart", 16'hC3C3, 2'd3);

    // R1 R3: no change after 23 edges, both fields applied after the 24th
    sel_n = 1'b0; #20;
    shift_bits(24'h02_7E81, 23);
    #80;
    chk_out("R1 pre-last", 16'hC3C3, 2'd3);
    shift_bits(24'h02_7E81 << 23, 1);
    #20;
    chk_out("R3 latency", 16'h7E81, 2'd2);

    // R5: extra edges with select still low are ignored
    shift_bits(24'hFF_FFFF, 8);
    #80;
    chk_out("R5 extra low", 16'h7E81, 2'd2);
    sel_n = 1'b1; #80;
    chk_out("R5 extra after", 16'h7E81, 2'd2);
    send_frame(24'h00_0042);
    chk_out("R5 next frame", 16'h0042, 2'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule